// File: doc/BRIEF.md
# Receive Frame Status Queue Tracker

This block follows the frames that sit in a receive data FIFO. It does not store any frame data. It keeps a short queue of per-frame records, each holding a normalised four-bit error class and a byte count. From the record at the head of that queue it builds a 16-bit status word for the host. The MAC side reports three kinds of event: the start of a frame, each byte, and the end of a frame together with an error class. The host side reads bytes of the head frame, discards the head frame, or resets the receiver.

The block counts how full the data FIFO is and raises three diagnostic flags:

- a status-overrun flag, high while the record queue is full;
- a data-overrun flag with hysteresis, set when the data FIFO is full;
- a sticky host-underrun flag, set when the host reads past the end of the available data. This flag also raises adapter failure.

Frames that cannot be accepted are dropped whole and leave no record. A frame longer than the maximum length is capped at that length and reported as oversize.

Top module: `rxq_status_tracker`

## Requirements
- R1: After rstN is low, or after a cycle with rxReset high, the status word is 16'h8000. rxComplete, rxReceiving, statusOverrun, dataOverrun, rxUnderrun and adapterFail are all low, and every queued record is gone.
- R2: While at least one completed frame is queued, rxComplete is high and the status word shows the oldest such frame: bit 15 = 0, bits 14..11 = its error code, bits 10..0 = its byte count.
- R3: The error codes 1000 (overrun), 1001 (oversize), 1011 (runt), 1100 (alignment) and 1101 (CRC) are stored as given, so bit 14 is 1 for these codes. The code 0010 (dribble) is stored as given, with bit 14 = 0. Every other code on frmErrCode is stored as 0000.
- R4: MAX_FRAME is 1514 by default. Bytes past MAX_FRAME are not stored. Such a frame is recorded with a byte count of MAX_FRAME and code 1001, whatever code is given at its end. A frame of exactly MAX_FRAME bytes keeps its own code.
- R5: While no completed frame is queued, bit 15 = 1, bits 14..11 = 0, and bits 10..0 give the bytes received so far of the frame in progress (0 if there is none). rxReceiving is high from an accepted frmStart until that frame ends or is dropped.
- R6: A discardTop removes the head record and shows the next one, in arrival order. A discardTop with no completed frame has no effect.
- R7: statusOverrun is high while QDEPTH (8) records are held. A frmStart in that state is refused, and the refused frame is never recorded. The flag falls once one record is removed.
- R8: dataOverrun sets when the FIFO fill reaches DATA_DEPTH. The following effects apply:
  - A byte that arrives while the FIFO is full drops its frame and frees that frame's bytes.
  - A frmStart while dataOverrun is high is refused.
  - Only a host read or discardTop clears the flag, and only when it leaves the fill at or below DATA_DEPTH-4.
- R9: A hostRead with no completed frame, or after every byte of the head frame has been read, sets rxUnderrun and adapterFail. Both stay set until rxReset or rstN.
- R10: When hostRead and discardTop are high in the same cycle, the discard takes effect, no byte is read, and no underrun is flagged.
- R11: A frmStart during a frame drops the unfinished frame. frmByte or frmEnd with no frame in progress, or in the same cycle as frmStart, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low global reset |
| frmStart | input | 1 | MAC: a new frame begins |
| frmByte | input | 1 | MAC: one byte of the current frame is written |
| frmEnd | input | 1 | MAC: the current frame ends |
| frmErrCode | input | 4 | MAC: error class, sampled with frmEnd |
| hostRead | input | 1 | Host reads one byte of the head frame |
| discardTop | input | 1 | Host drops the head frame |
| rxReset | input | 1 | Synchronous receiver reset command |
| rxStatus | output | 16 | Head-frame status word |
| rxComplete | output | 1 | A completed frame is at the head |
| rxReceiving | output | 1 | A frame is being written |
| statusOverrun | output | 1 | Record queue full |
| dataOverrun | output | 1 | Data FIFO overrun, with hysteresis |
| rxUnderrun | output | 1 | Sticky host read-past-end flag |
| adapterFail | output | 1 | Adapter failure raised by underrun |

## Verification
Every event is sampled on a rising edge. Every output is decoded from registers that this edge updates, so each result is due exactly one cycle after its stimulus; no output answers combinationally to an input. The bench drives inputs on the falling edge. It then compares all outputs on the next falling edge, against a queue model kept in bench functions and against literal status words for the directed cases. Hysteresis and stickiness are checked by sampling a flag on the cycles just after the events that must not move it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam logic [3:0] CODE_NONE     = 4'b0000;
  localparam logic [3:0] CODE_DRIBBLE  = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b1000;
  localparam logic [3:0] CODE_OVERSIZE = 4'b1001;
  localparam logic [3:0] CODE_RUNT     = 4'b1011;
  localparam logic [3:0] CODE_ALIGN    = 4'b1100;
  localparam logic [3:0] CODE_CRC      = 4'b1101;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startFrame;
    logic takeByte;
    logic markOversize;
    logic dropFrame;
    logic pushFrame;
    logic popHead;
    logic readByte;
    logic flagUnderrun;
    logic flushAll;
  } rxq_strobe_t;

  function automatic logic [3:0] normalizeCode(input logic [3:0] raw);
    logic [3:0] res;
    case (raw)
      CODE_DRIBBLE, CODE_OVERRUN, CODE_OVERSIZE,
      CODE_RUNT, CODE_ALIGN, CODE_CRC: res = raw;
      default:                         res = CODE_NONE;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmStart,
  input  logic        frmByte,
  input  logic        frmEnd,
  input  logic        hostRead,
  input  logic        discardTop,
  input  logic        rxReset,
  input  logic        qFull,
  input  logic        qEmpty,
  input  logic        fifoFull,
  input  logic        dataOvr,
  input  logic        headDone,
  input  logic        curAtMax,
  output rxq_strobe_t strb,
  output logic        receiving
);

  logic active;
  logic activeNext;
  logic byteLost;

  always_comb begin
    strb       = '0;
    activeNext = active;
    byteLost   = 1'b0;
    if (rxReset) begin
      strb.flushAll = 1'b1;
      activeNext    = 1'b0;
    end else begin
      // host side
      strb.popHead      = discardTop && !qEmpty;
      strb.readByte     = hostRead && !discardTop && !qEmpty && !headDone;
      strb.flagUnderrun = hostRead && !discardTop && (qEmpty || headDone);
      // wire side
      if (frmStart) begin
        strb.dropFrame = active;
        if (!(qFull || dataOvr)) begin
          strb.startFrame = 1'b1;
          activeNext      = 1'b1;
        end else begin
          activeNext = 1'b0;
        end
      end else if (active) begin
        if (frmByte) begin
          if (curAtMax) begin
            strb.markOversize = 1'b1;
          end else if (fifoFull) begin
            strb.dropFrame = 1'b1;
            byteLost       = 1'b1;
            activeNext     = 1'b0;
          end else begin
            strb.takeByte = 1'b1;
          end
        end
        if (frmEnd && !byteLost) begin
          strb.pushFrame = 1'b1;
          activeNext     = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= activeNext;
  end

  assign receiving = active;

  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushFrame |-> !qFull);  // R7
  AST_HOST_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.popHead, strb.readByte, strb.flagUnderrun}));  // R10
  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeByte |-> receiving);  // R5

endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int QDEPTH        = 8,
  parameter int DATA_DEPTH    = 2048,
  parameter int MAX_FRAME     = 1514,
  parameter int RESUME_MARGIN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  rxq_strobe_t strb,
  input  logic [3:0]  macCode,
  output logic        qFull,
  output logic        qEmpty,
  output logic        fifoFull,
  output logic        dataOvr,
  output logic        headDone,
  output logic        curAtMax,
  output logic        underrun,
  output logic [15:0] statusWord
);

  localparam int LEN_W  = $clog2(MAX_FRAME + 1);
  localparam int OCC_W  = $clog2(DATA_DEPTH + 1);
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCNT_W = $clog2(QDEPTH + 1);
  localparam int STAT_W = 11;

  logic [3:0]       codeMem [QDEPTH];
  logic [LEN_W-1:0] lenMem  [QDEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [QCNT_W-1:0] qCount;
  logic [LEN_W-1:0] headRead, curCount;
  logic             curOv;
  logic [OCC_W-1:0] occ, occNext, popAmt, dropAmt;
  logic             dataOvrNext;
  logic [LEN_W-1:0] headLen;
  logic [3:0]       headCode;
  logic [LEN_W-1:0] pushLen;
  logic [3:0]       pushCode;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headLen  = lenMem[rdPtr];
  assign headCode = codeMem[rdPtr];
  assign qFull    = (qCount == QCNT_W'(QDEPTH));
  assign qEmpty   = (qCount == '0);
  assign fifoFull = (occ == OCC_W'(DATA_DEPTH));
  assign headDone = (headRead == headLen);
  assign curAtMax = (curCount == LEN_W'(MAX_FRAME));

  assign pushLen  = curCount + LEN_W'(strb.takeByte);
  assign pushCode = (curOv || strb.markOversize) ? CODE_OVERSIZE : normalizeCode(macCode);

  // fill level of the data FIFO after this cycle's moves
  always_comb begin
    popAmt  = strb.popHead   ? OCC_W'(headLen - headRead) : '0;
    dropAmt = strb.dropFrame ? OCC_W'(curCount)           : '0;
    occNext = occ + OCC_W'(strb.takeByte) - OCC_W'(strb.readByte) - popAmt - dropAmt;
    if (occNext == OCC_W'(DATA_DEPTH))
      dataOvrNext = 1'b1;
    else if ((strb.popHead || strb.readByte) &&
             occNext <= OCC_W'(DATA_DEPTH - RESUME_MARGIN))
      dataOvrNext = 1'b0;
    else
      dataOvrNext = dataOvr;
  end

  // record storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) begin
        codeMem[i] <= '0;
        lenMem[i]  <= '0;
      end
    end else if (strb.pushFrame && !strb.flushAll) begin
      codeMem[wrPtr] <= pushCode;
      lenMem[wrPtr]  <= pushLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      qCount   <= '0;
      headRead <= '0;
      curCount <= '0;
      curOv    <= 1'b0;
      occ      <= '0;
      dataOvr  <= 1'b0;
      underrun <= 1'b0;
    end else if (strb.flushAll) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      qCount   <= '0;
      headRead <= '0;
      curCount <= '0;
      curOv    <= 1'b0;
      occ      <= '0;
      dataOvr  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (strb.pushFrame) wrPtr <= nextPtr(wrPtr);
      if (strb.popHead)   rdPtr <= nextPtr(rdPtr);
      qCount <= qCount + QCNT_W'(strb.pushFrame) - QCNT_W'(strb.popHead);
      if (strb.popHead)       headRead <= '0;
      else if (strb.readByte) headRead <= headRead + 1'b1;
      if (strb.startFrame || strb.dropFrame || strb.pushFrame) begin
        curCount <= '0;
        curOv    <= 1'b0;
      end else begin
        if (strb.takeByte)     curCount <= curCount + 1'b1;
        if (strb.markOversize) curOv    <= 1'b1;
      end
      occ     <= occNext;
      dataOvr <= dataOvrNext;
      if (strb.flagUnderrun) underrun <= 1'b1;
    end
  end

  assign statusWord = qEmpty ? {1'b1, 4'b0000, STAT_W'(curCount)}
                             : {1'b0, headCode, STAT_W'(headLen)};

  AST_QCOUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= QCNT_W'(QDEPTH));  // R7
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DATA_DEPTH));  // R8
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !strb.flushAll) |=> underrun);  // R9
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    curCount <= LEN_W'(MAX_FRAME));  // R4
  AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strb.readByte |-> (headRead < headLen));  // R9
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dropFrame && !strb.flushAll) |=> (curCount == '0));  // R11

endmodule

// File: rtl/rxq_status_tracker.sv
module rxq_status_tracker
  import rxq_pkg::*;
#(
  parameter int QDEPTH        = 8,
  parameter int DATA_DEPTH    = 2048,
  parameter int MAX_FRAME     = 1514,
  parameter int RESUME_MARGIN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmStart,
  input  logic        frmByte,
  input  logic        frmEnd,
  input  logic [3:0]  frmErrCode,
  input  logic        hostRead,
  input  logic        discardTop,
  input  logic        rxReset,
  output logic [15:0] rxStatus,
  output logic        rxComplete,
  output logic        rxReceiving,
  output logic        statusOverrun,
  output logic        dataOverrun,
  output logic        rxUnderrun,
  output logic        adapterFail
);

  rxq_strobe_t strb;
  logic qFull, qEmpty, fifoFull, dataOvr, headDone, curAtMax, underrun;

  rxq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frmStart   (frmStart),
    .frmByte    (frmByte),
    .frmEnd     (frmEnd),
    .hostRead   (hostRead),
    .discardTop (discardTop),
    .rxReset    (rxReset),
    .qFull      (qFull),
    .qEmpty     (qEmpty),
    .fifoFull   (fifoFull),
    .dataOvr    (dataOvr),
    .headDone   (headDone),
    .curAtMax   (curAtMax),
    .strb       (strb),
    .receiving  (rxReceiving)
  );

  rxq_datapath #(
    .QDEPTH        (QDEPTH),
    .DATA_DEPTH    (DATA_DEPTH),
    .MAX_FRAME     (MAX_FRAME),
    .RESUME_MARGIN (RESUME_MARGIN)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .macCode    (frmErrCode),
    .qFull      (qFull),
    .qEmpty     (qEmpty),
    .fifoFull   (fifoFull),
    .dataOvr    (dataOvr),
    .headDone   (headDone),
    .curAtMax   (curAtMax),
    .underrun   (underrun),
    .statusWord (rxStatus)
  );

  assign rxComplete    = !qEmpty;
  assign statusOverrun = qFull;
  assign dataOverrun   = dataOvr;
  assign rxUnderrun    = underrun;
  assign adapterFail   = underrun;

endmodule

// File: tb/rxq_status_tracker_tb.sv
`timescale 1ns/1ps
module rxq_status_tracker_tb_top;

  localparam int QD = 8;
  localparam int DEPTH = 2048;
  localparam int MAXF = 1514;
  localparam int MARGIN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frmStart = 0, frmByte = 0, frmEnd = 0, hostRead = 0, discardTop = 0, rxReset = 0;
  logic [3:0] frmErrCode = '0;
  logic [15:0] rxStatus;
  logic rxComplete, rxReceiving, statusOverrun, dataOverrun, rxUnderrun, adapterFail;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxq_status_tracker dut_i (
    .clk(clk), .rstN(rstN), .frmStart(frmStart), .frmByte(frmByte), .frmEnd(frmEnd),
    .frmErrCode(frmErrCode), .hostRead(hostRead), .discardTop(discardTop), .rxReset(rxReset),
    .rxStatus(rxStatus), .rxComplete(rxComplete), .rxReceiving(rxReceiving),
    .statusOverrun(statusOverrun), .dataOverrun(dataOverrun), .rxUnderrun(rxUnderrun),
    .adapterFail(adapterFail)
  );

  // reference model state
  int mLen[QD];
  int mCode[QD];
  int mN, mHd, mCur, mOcc;
  bit mAct, mCurOv, mDOvr, mUnd;

  function automatic int normCode(input int c);
    if (c == 4'b1000 || c == 4'b1001 || c == 4'b1011 || c == 4'b1100 ||
        c == 4'b1101 || c == 4'b0010) return c;
    return 0;
  endfunction

  function automatic void modelReset();
    mN = 0; mHd = 0; mCur = 0; mOcc = 0;
    mAct = 0; mCurOv = 0; mDOvr = 0; mUnd = 0;
  endfunction

  function automatic void modelApply(bit s, bit b, bit e, int c, bit rd, bit dc, bit rr);
    bit headOk, pop, rdk, und, take, drop, push, ovs, startOk, newAct, lost;
    int popAmt, dropAmt, occN, pLen, pCode;
    if (rr) begin modelReset(); return; end
    headOk = (mN > 0) && (mHd < mLen[0]);
    pop = dc && (mN > 0);
    rdk = rd && !dc && headOk;
    und = rd && !dc && !headOk;
    take = 0; drop = 0; push = 0; ovs = 0; startOk = 0; lost = 0; newAct = mAct; dropAmt = 0;
    if (s) begin
      if (mAct) begin drop = 1; dropAmt = mCur; end
      if (!(mN == QD || mDOvr)) begin startOk = 1; newAct = 1; end
      else newAct = 0;
    end else if (mAct) begin
      if (b) begin
        if (mCur == MAXF) ovs = 1;
        else if (mOcc == DEPTH) begin drop = 1; dropAmt = mCur; lost = 1; newAct = 0; end
        else take = 1;
      end
      if (e && !lost) begin push = 1; newAct = 0; end
    end
    popAmt = pop ? (mLen[0] - mHd) : 0;
    occN = mOcc + int'(take) - int'(rdk) - popAmt - dropAmt;
    pLen = mCur + int'(take);
    pCode = (mCurOv || ovs) ? 9 : normCode(c);
    if (pop) begin
      for (int i = 0; i < QD - 1; i++) begin mLen[i] = mLen[i+1]; mCode[i] = mCode[i+1]; end
      mN--; mHd = 0;
    end else if (rdk) mHd++;
    if (push) begin mLen[mN] = pLen; mCode[mN] = pCode; mN++; end
    if (startOk || drop || push) begin mCur = 0; mCurOv = 0; end
    else begin
      if (take) mCur++;
      if (ovs) mCurOv = 1;
    end
    if (und) mUnd = 1;
    if (occN == DEPTH) mDOvr = 1;
    else if ((pop || rdk) && occN <= DEPTH - MARGIN) mDOvr = 0;
    mOcc = occN;
    mAct = newAct;
  endfunction

  function automatic logic [15:0] expWord();
    if (mN > 0) return {1'b0, 4'(mCode[0]), 11'(mLen[0])};
    return {1'b1, 4'b0000, 11'(mCur)};
  endfunction

  task automatic chkModel(input string req);
    logic [15:0] w;
    w = expWord();
    checks++;
    if (rxStatus !== w || rxComplete !== (mN > 0) || rxReceiving !== mAct ||
        statusOverrun !== (mN == QD) || dataOverrun !== mDOvr ||
        rxUnderrun !== mUnd || adapterFail !== mUnd) begin
      failures++;
      $display("FAIL %s: got status=%h cmp=%b recv=%b sovr=%b dovr=%b und=%b fail=%b exp status=%h cmp=%b recv=%b sovr=%b dovr=%b und=%b",
               req, rxStatus, rxComplete, rxReceiving, statusOverrun, dataOverrun, rxUnderrun,
               adapterFail, w, (mN > 0), mAct, (mN == QD), mDOvr, mUnd);
    end
  endtask

  task automatic chkWord(input logic [15:0] exp, input string req);
    checks++;
    if (rxStatus !== exp) begin
      failures++;
      $display("FAIL %s: status got %h expected %h", req, rxStatus, exp);
    end
  endtask

  task automatic chkBit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: flag got %b expected %b", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, model at rising edge, return at next falling edge
  task automatic cyc(input bit s, input bit b, input bit e, input logic [3:0] c,
                     input bit rd, input bit dc, input bit rr);
    frmStart = s; frmByte = b; frmEnd = e; frmErrCode = c;
    hostRead = rd; discardTop = dc; rxReset = rr;
    @(posedge clk);
    modelApply(s, b, e, int'(c), rd, dc, rr);
    @(negedge clk);
    frmStart = 0; frmByte = 0; frmEnd = 0; hostRead = 0; discardTop = 0; rxReset = 0;
  endtask

  task automatic sendFrame(input int n, input logic [3:0] c);
    cyc(1, 0, 0, 4'h0, 0, 0, 0);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 4'h0, 0, 0, 0);
    cyc(0, 0, 1, c, 0, 0, 0);
  endtask

  task automatic idle(); cyc(0, 0, 0, 4'h0, 0, 0, 0); endtask
  task automatic doReset(); cyc(0, 0, 0, 4'h0, 0, 0, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd4711);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkWord(16'h8000, "R1");
    chkModel("R1");

    // R2 R3: CRC frame of 60 bytes
    sendFrame(60, 4'b1101);
    chkWord(16'h683C, "R2");
    chkBit(rxComplete, 1'b1, "R2");
    chkModel("R3");

    // R5: partial frame behind a completed head, then discard shows it
    cyc(1, 0, 0, 4'h0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 4'h0, 0, 0, 0);
    chkWord(16'h683C, "R6");
    cyc(0, 0, 0, 4'h0, 0, 1, 0);
    chkWord(16'h8005, "R5");
    chkBit(rxReceiving, 1'b1, "R5");
    cyc(0, 0, 1, 4'b0010, 0, 0, 0);
    chkWord(16'h1005, "R3");
    chkBit(rxReceiving, 1'b0, "R5");

    // R3 unknown code stored as zero, R6 ordering
    sendFrame(3, 4'b1010);
    chkWord(16'h1005, "R6");
    // R9: read all five bytes, then past end
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 4'h0, 1, 0, 0);
    chkBit(rxUnderrun, 1'b0, "R9");
    cyc(0, 0, 0, 4'h0, 1, 0, 0);
    chkBit(rxUnderrun, 1'b1, "R9");
    chkBit(adapterFail, 1'b1, "R9");
    cyc(0, 0, 0, 4'h0, 0, 1, 0);
    chkWord(16'h0003, "R3");
    chkBit(rxUnderrun, 1'b1, "R9");
    // R10 read with discard: discard wins, no byte counted
    cyc(0, 0, 0, 4'h0, 1, 1, 0);
    chkWord(16'h8000, "R10");
    chkModel("R10");
    doReset();
    chkModel("R1");
    chkBit(rxUnderrun, 1'b0, "R1");
    // R6 discard on empty queue has no effect
    cyc(0, 0, 0, 4'h0, 0, 1, 0);
    chkWord(16'h8000, "R6");

    // R7 status overrun
    for (int k = 0; k < QD; k++) sendFrame(k + 1, 4'b1011);
    chkBit(statusOverrun, 1'b1, "R7");
    cyc(1, 0, 0, 4'h0, 0, 0, 0);
    chkBit(rxReceiving, 1'b0, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 4'h0, 0, 0, 0);
    cyc(0, 0, 1, 4'h0, 0, 0, 0);
    chkModel("R7");
    cyc(0, 0, 0, 4'h0, 0, 1, 0);
    chkBit(statusOverrun, 1'b0, "R7");
    chkWord(16'h5802, "R7");
    for (int k = 1; k < QD; k++) cyc(0, 0, 0, 4'h0, 0, 1, 0);
    chkWord(16'h8000, "R7");

    // R4 oversize and exact maximum
    doReset();
    sendFrame(1520, 4'b0000);
    chkWord(16'h4DEA, "R4");
    doReset();
    sendFrame(1514, 4'b1100);
    chkWord(16'h65EA, "R4");

    // R8 hysteresis
    doReset();
    sendFrame(1514, 4'b0000);
    sendFrame(534, 4'b0000);
    chkBit(dataOverrun, 1'b1, "R8");
    cyc(1, 0, 0, 4'h0, 0, 0, 0);
    chkBit(rxReceiving, 1'b0, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 4'h0, 1, 0, 0);
    chkBit(dataOverrun, 1'b1, "R8");
    cyc(0, 0, 0, 4'h0, 1, 0, 0);
    chkBit(dataOverrun, 1'b0, "R8");
    chkModel("R8");

    // R8 byte at full drops frame
    doReset();
    sendFrame(1514, 4'b0000);
    cyc(1, 0, 0, 4'h0, 0, 0, 0);
    for (int i = 0; i < 534; i++) cyc(0, 1, 0, 4'h0, 0, 0, 0);
    chkBit(dataOverrun, 1'b1, "R8");
    cyc(0, 1, 1, 4'h0, 0, 0, 0);
    chkBit(rxReceiving, 1'b0, "R8");
    chkBit(dataOverrun, 1'b1, "R8");
    cyc(0, 0, 0, 4'h0, 0, 1, 0);
    chkWord(16'h8000, "R8");
    chkBit(dataOverrun, 1'b0, "R8");

    // R11 restart drops unfinished frame; idle events ignored
    doReset();
    cyc(1, 0, 0, 4'h0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 4'h0, 0, 0, 0);
    cyc(1, 1, 0, 4'h0, 0, 0, 0);
    chkWord(16'h8000, "R11");
    cyc(0, 1, 0, 4'h0, 0, 0, 0);
    cyc(0, 1, 0, 4'h0, 0, 0, 0);
    cyc(0, 0, 1, 4'b1000, 0, 0, 0);
    chkWord(16'h4002, "R11");
    cyc(0, 1, 0, 4'h0, 0, 0, 0);
    cyc(0, 0, 1, 4'h0, 0, 0, 0);
    chkWord(16'h4002, "R11");
    chkModel("R11");

    // constrained random against the model
    doReset();
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom % 16);
      cyc(r == 0, (r >= 1 && r <= 10), (r == 11 || r == 12), 4'($urandom % 16),
          ($urandom % 4) == 0, ($urandom % 20) == 0, ($urandom % 700) == 0);
      chkModel("R2");
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule